// File: doc/BRIEF.md
# SPI Serial Memory Target

This block is the target side of an SPI link in front of a small byte-addressed memory of 2 KB, kept in flip-flops. A bus master lowers chip select and sends a one-byte command, most significant bit first. The block recognises six commands. Two of them set and clear a write-enable flag. Two read and write a small status register. The last two stream data out of the array and into it. Every write to the status register or to the array is gated by the write-enable flag. That flag is set only by its own command, and it drops when chip select rises at the end of a write-type command.

The serial pins are sampled on a system clock through a synchronizer, and SCK edges are found in that clock domain. SCK may idle low (mode 0) or high (mode 3). No configuration is needed, because only rising edges seen after chip select falls are counted. Serial data out comes as a value plus an output enable, so that the pad ring can build the tri-state driver.

Top module: `spi_mem_target`

## Requirements
- R1: SPI mode 0 (SCK idles low) and mode 3 (SCK idles high) both work without configuration. SI is captured on SCK rising edges, counting from the first rising edge after chip select falls. In mode 3 the high level present at selection is not an edge.
- R2: The first byte after selection is the command, MSB first, with these codes: 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read data, 0x02 write data.
- R3: Read status returns, MSB first, the byte {4'b0000, prot[1:0], wel, 1'b0}, with wel at bit 1. It repeats that byte for as long as clocking continues.
- R4: After reset wel is 0. Only the 0x06 command sets it. Writing bit 1 through write status does not change it.
- R5: While wel is 0, write status and write data leave the status byte and the array unchanged.
- R6: wel drops on the rising edge of chip select that ends a 0x04, 0x01 or 0x02 command. A 0x06 command leaves it set.
- R7: Write status with wel set stores data bits 3:2 into prot[1:0]. The other bits are ignored.
- R8: Read data and write data take a two-byte address, MSB first, of which only the low 11 bits are used. Data then streams with the address incremented after each byte, wrapping from 0x7FF to 0x000.
- R9: A write data byte is committed only after all 8 of its bits have arrived. A partial last byte is dropped when chip select rises.
- R10: An unknown command is ignored until deselection. Raising chip select at any point resets the bit count and the command state, so the next selection starts a fresh command.
- R11: so_oe_o is 1 only while selected in the data phase of read status or read data. The first data bit appears right after the last command or address bit is captured, and later bits change on SCK falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the master |
| si_i | input | 1 | Serial data from the master |
| so_o | output | 1 | Serial data to the master |
| so_oe_o | output | 1 | Output enable for the SO pad driver |

## Verification
The bench builds the block with its default values: an 11-bit address and two synchronizer stages. Because the address is the default 11 bits, the wrap from 0x7FF to 0x000 and the masking of address bits above bit 10 can be reached with a handful of short streaming transfers. SCK runs at one sixteenth of the system clock. This leaves room for the synchronizer and edge-detect latency before each output bit is sampled. Random commands, modes, lengths and addresses are drawn near both ends of the array, so the wrap is crossed often in both modes.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_OP,
    PH_AHI,
    PH_ALO,
    PH_DATA,
    PH_IDLE
  } phase_e;

  typedef enum logic [2:0] {
    C_NONE,
    C_RDSR,
    C_WRSR,
    C_READ,
    C_WRITE
  } cmd_e;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= {STAGES{RST_VAL}};
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_n_s_i,
  input  logic          sck_s_i,
  input  logic          si_s_i,
  output logic          so_o,
  output logic          so_oe_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [7:0]    mem_wdata_o,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [7:0]    mem_rdata_i
);

  localparam int unsigned HW = AW - 8;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic          cs_q, sck_q;
  logic [2:0]    bit_cnt_q;
  logic [6:0]    in_sr_q;
  logic [7:0]    out_sr_q;
  logic          oe_q, wel_q, clr_pend_q;
  logic [1:0]    prot_q;
  logic [AW-1:0] addr_q;
  phase_e        phase_q;
  cmd_e          cmd_q;

  logic          cs_act, rise, fall, cs_rise, byte_done;
  logic [7:0]    byte_in, status;
  logic [AW-1:0] addr_inc;

  assign cs_act    = ~cs_n_s_i;
  assign rise      = cs_act & sck_s_i & ~sck_q;
  assign fall      = cs_act & ~sck_s_i & sck_q;
  assign cs_rise   = cs_n_s_i & ~cs_q;
  assign byte_in   = {in_sr_q, si_s_i};
  assign byte_done = rise && (bit_cnt_q == 3'd7);
  assign status    = {4'b0000, prot_q, wel_q, 1'b0};
  assign addr_inc  = addr_q + ONE;

  assign mem_we_o    = byte_done && phase_q == PH_DATA && cmd_q == C_WRITE && wel_q;
  assign mem_waddr_o = addr_q;
  assign mem_wdata_o = byte_in;
  assign mem_raddr_o = (phase_q == PH_ALO) ? {addr_q[AW-1:8], byte_in} : addr_inc;

  assign so_o    = out_sr_q[7];
  assign so_oe_o = oe_q & cs_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b1;
      sck_q      <= 1'b0;
      bit_cnt_q  <= '0;
      in_sr_q    <= '0;
      out_sr_q   <= '0;
      oe_q       <= 1'b0;
      wel_q      <= 1'b0;
      clr_pend_q <= 1'b0;
      prot_q     <= '0;
      addr_q     <= '0;
      phase_q    <= PH_OP;
      cmd_q      <= C_NONE;
    end else begin
      cs_q  <= cs_n_s_i;
      sck_q <= sck_s_i;
      if (cs_rise) begin
        bit_cnt_q  <= '0;
        phase_q    <= PH_OP;
        cmd_q      <= C_NONE;
        oe_q       <= 1'b0;
        clr_pend_q <= 1'b0;
        if (clr_pend_q) wel_q <= 1'b0;
      end else if (rise) begin
        bit_cnt_q <= bit_cnt_q + 3'd1;
        in_sr_q   <= byte_in[6:0];
        if (bit_cnt_q == 3'd7) begin
          case (phase_q)
            PH_OP: begin
              phase_q <= PH_IDLE;
              case (byte_in)
                OP_WREN: wel_q <= 1'b1;
                OP_WRDI: clr_pend_q <= 1'b1;
                OP_RDSR: begin
                  cmd_q    <= C_RDSR;
                  phase_q  <= PH_DATA;
                  out_sr_q <= status;
                  oe_q     <= 1'b1;
                end
                OP_WRSR: begin
                  cmd_q      <= C_WRSR;
                  phase_q    <= PH_DATA;
                  clr_pend_q <= 1'b1;
                end
                OP_READ: begin
                  cmd_q   <= C_READ;
                  phase_q <= PH_AHI;
                end
                OP_WRITE: begin
                  cmd_q      <= C_WRITE;
                  phase_q    <= PH_AHI;
                  clr_pend_q <= 1'b1;
                end
                default: ;
              endcase
            end
            PH_AHI: begin
              addr_q[AW-1:8] <= byte_in[HW-1:0];
              phase_q        <= PH_ALO;
            end
            PH_ALO: begin
              addr_q[7:0] <= byte_in;
              phase_q     <= PH_DATA;
              if (cmd_q == C_READ) begin
                out_sr_q <= mem_rdata_i;
                oe_q     <= 1'b1;
              end
            end
            PH_DATA: begin
              case (cmd_q)
                C_RDSR:  out_sr_q <= status;
                C_WRSR:  if (wel_q) prot_q <= byte_in[3:2];
                C_READ: begin
                  addr_q   <= addr_inc;
                  out_sr_q <= mem_rdata_i;
                end
                C_WRITE: addr_q <= addr_inc;
                default: ;
              endcase
            end
            default: ;
          endcase
        end
      end else if (fall && bit_cnt_q != 3'd0) begin
        // first bit of a byte is held through the fall that follows its load
        out_sr_q <= {out_sr_q[6:0], 1'b0};
      end
    end
  end

  assert_wel_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(byte_done && phase_q == PH_OP && byte_in == OP_WREN));

  assert_prot_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wel_q |=> $stable(prot_q));

  assert_wel_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && clr_pend_q) |=> !wel_q);

  assert_cs_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (bit_cnt_q == 3'd0 && phase_q == PH_OP));

  assert_oe_phase_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> phase_q == PH_DATA);

endmodule

// File: rtl/spi_mem_target.sv
module spi_mem_target #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o
);

  logic [2:0]        pins_s;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata, mem_rdata;

  spi_mem_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i}),
    .q_o   (pins_s)
  );

  spi_mem_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_s_i   (pins_s[2]),
    .sck_s_i    (pins_s[1]),
    .si_s_i     (pins_s[0]),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o),
    .mem_we_o   (mem_we),
    .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata),
    .mem_raddr_o(mem_raddr),
    .mem_rdata_i(mem_rdata)
  );

  spi_mem_array #(.AW(ADDR_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(mem_raddr),
    .rdata_o(mem_rdata)
  );

endmodule

// File: tb/spi_mem_target_test.sv
`timescale 1ns/1ps
module spi_mem_target_test;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int mode = 0;
  logic oe_any, oe_all;

  logic [7:0] mm [2048];
  bit         kn [2048];
  logic       mwel = 1'b0;
  logic [1:0] mprot = 2'b00;

  always #10 clk = ~clk;

  spi_mem_target uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cs_ni  (cs_n),
    .sck_i  (sck),
    .si_i   (si),
    .so_o   (so),
    .so_oe_o(so_oe)
  );

  function automatic logic [7:0] exp_status();
    return {4'b0000, mprot, mwel, 1'b0};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic sel(input int md);
    mode = md;
    sck = (md == 3);
    tick(4);
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic desel();
    if (mode == 0) begin
      sck = 1'b0;
      tick(HALF);
    end
    tick(2);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic xfer(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    oe_any = 1'b0;
    oe_all = 1'b1;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0;
      si = tx[i];
      tick(HALF);
      rx = {rx[6:0], so};
      oe_any |= so_oe;
      oe_all &= so_oe;
      sck = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic do_op(input int md, input logic [7:0] op);
    logic [7:0] rx;
    sel(md);
    xfer(op, 8, rx);
    chk1("R2 R11 opcode-only keeps SO off", oe_any, 1'b0);
    desel();
    if (op == 8'h06) mwel = 1'b1;
    if (op == 8'h04) mwel = 1'b0;
  endtask

  task automatic do_rdsr(input int md, input int n, input string req);
    logic [7:0] rx;
    sel(md);
    xfer(8'h05, 8, rx);
    chk1("R11 SO off during opcode", oe_any, 1'b0);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, rx);
      chk8(req, rx, exp_status());
      chk1("R11 SO on in status data", oe_all, 1'b1);
    end
    desel();
  endtask

  task automatic do_wrsr(input int md, input logic [7:0] d);
    logic [7:0] rx;
    sel(md);
    xfer(8'h01, 8, rx);
    xfer(d, 8, rx);
    chk1("R11 SO off during write status", oe_any, 1'b0);
    desel();
    if (mwel) mprot = d[3:2];
    mwel = 1'b0;
  endtask

  task automatic do_write(input int md, input logic [15:0] a, input int n, input int part);
    logic [7:0] rx, d;
    logic [10:0] idx;
    idx = a[10:0];
    sel(md);
    xfer(8'h02, 8, rx);
    xfer(a[15:8], 8, rx);
    xfer(a[7:0], 8, rx);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      xfer(d, 8, rx);
      if (mwel) begin
        mm[idx] = d;
        kn[idx] = 1'b1;
      end
      idx = idx + 11'd1;
    end
    if (part > 0) xfer(8'($urandom), part, rx);
    desel();
    mwel = 1'b0;
  endtask

  task automatic do_read(input int md, input logic [15:0] a, input int n, input string req);
    logic [7:0] rx;
    logic [10:0] idx;
    idx = a[10:0];
    sel(md);
    xfer(8'h03, 8, rx);
    xfer(a[15:8], 8, rx);
    xfer(a[7:0], 8, rx);
    chk1("R11 SO off during address", oe_any, 1'b0);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, rx);
      chk1("R11 SO on in read data", oe_all, 1'b1);
      if (kn[idx]) chk8(req, rx, mm[idx]);
      idx = idx + 11'd1;
    end
    desel();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    void'($urandom(32'd2024));
    for (int i = 0; i < 2048; i++) kn[i] = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    chk1("R11 reset SO disabled", so_oe, 1'b0);
    do_rdsr(0, 2, "R4 R3 reset status");
    do_rdsr(3, 2, "R1 R3 mode 3 status");

    do_wrsr(0, 8'hFF);
    do_rdsr(0, 1, "R5 write status locked");
    do_wrsr(3, 8'h02);
    do_rdsr(3, 1, "R4 WRSR cannot set wel");

    do_op(3, 8'h06);
    do_rdsr(0, 2, "R4 R6 wel set by 0x06 and kept");
    do_op(0, 8'h04);
    do_rdsr(3, 1, "R6 wel cleared by 0x04");

    do_op(0, 8'h06);
    do_wrsr(0, 8'hFE);
    do_rdsr(0, 1, "R7 R6 protect bits stored, wel dropped");
    do_op(3, 8'h06);
    do_wrsr(3, 8'h04);
    do_rdsr(0, 1, "R7 protect bits rewritten");

    do_op(0, 8'h06);
    do_write(0, 16'hF7FE, 4, 0);
    do_rdsr(0, 1, "R6 wel dropped after write");
    do_read(0, 16'h07FE, 4, "R8 wrap 0x7FF to 0x000");
    do_read(3, 16'hA7FF, 2, "R8 upper address bits ignored");

    do_write(3, 16'h07FE, 2, 0);
    do_read(0, 16'h07FE, 2, "R5 array locked without wel");

    do_op(0, 8'h06);
    do_write(0, 16'h0010, 2, 0);
    do_op(3, 8'h06);
    do_write(3, 16'h0010, 1, 5);
    do_read(0, 16'h0010, 2, "R9 partial byte dropped");

    sel(0);
    xfer(8'hA5, 8, rx);
    xfer(8'h05, 8, rx);
    xfer(8'hFF, 8, rx);
    chk1("R10 unknown opcode keeps SO off", oe_any, 1'b0);
    desel();
    do_rdsr(0, 1, "R10 status after unknown opcode");

    sel(3);
    xfer(8'h06, 5, rx);
    desel();
    do_rdsr(3, 1, "R10 aborted opcode leaves wel");
    sel(0);
    xfer(8'h00, 3, rx);
    desel();
    do_rdsr(0, 1, "R10 R1 fresh command after abort");

    for (int it = 0; it < 60; it++) begin
      int md, sel_op, n;
      logic [15:0] a;
      md = ($urandom % 2 == 0) ? 0 : 3;
      sel_op = int'($urandom % 8);
      n = 1 + int'($urandom % 4);
      a = {5'($urandom), 11'(($urandom % 32) + 2032)};
      case (sel_op)
        0, 1: do_op(md, 8'h06);
        2: do_op(md, 8'h04);
        3: do_rdsr(md, n, "R3 R1 random status");
        4: do_wrsr(md, 8'($urandom));
        5: do_write(md, a, n, int'($urandom % 3) * 3);
        6: do_read(md, a, n, "R8 R1 random read");
        default: do_op(md, 8'h80 | 8'($urandom % 64));
      endcase
    end

    finish_run();
  end

endmodule